// File: doc/BRIEF.md
# USB IN Endpoint Transfer Controller

This block decides what a USB device returns each time the host polls one bulk or interrupt IN endpoint. Its transmit FIFO is filled by the CPU and the block sees only the current byte count. On every IN token it issues one registered decision. The decision is either a NAK, or a data packet of N bytes, where N may be zero.

A transfer-done flag chooses between two answering policies. While the flag is set (after reset, or after a transfer has finished), the endpoint sends only packets of the full maximum size and NAKs whenever the FIFO holds less. When software clears the flag after writing the last byte of a transfer, the endpoint drains whatever remains. It finishes with a short or zero-length packet, and hardware then raises the flag again by itself.

Two further functions sit beside the decision path. A debug one-shot marks the next data packet for a corrupted CRC. A sticky interrupt fires when FIFO occupancy drops to a selectable threshold. FIFO bytes are released only after the host acknowledges a packet.

Top module: `inEpTransferCtl`

## Requirements
- R1: After reset, doneFlag is 1 and replyValid, fifoAdvance and lvlIrq are 0.
- R2: A token sampled at a clock edge produces a one-cycle replyValid in the following cycle. While doneFlag is 1, the reply is DATA (replyIsData=1) with replyLen equal to maxPkt if fifoCount is at least maxPkt. Otherwise it is a NAK (replyIsData=0, replyLen=0).
- R3: While doneFlag is 0, every token is answered with DATA of length min(fifoCount, maxPkt). An empty FIFO gives a zero-length DATA reply.
- R4: A software write (swDoneWr with swDoneVal) loads doneFlag at the next edge. If an end-of-transfer event occurs in the same cycle, the flag ends up 1.
- R5: A DATA reply shorter than maxPkt, including zero length, is an end of transfer. It sets doneFlag in the same cycle that replyValid is high.
- R6: A DATA reply of exactly maxPkt leaves doneFlag unchanged. With doneFlag 0, a following token on an empty FIFO returns a zero-length packet that ends the transfer.
- R7: A NAK never moves the FIFO. After a DATA reply, the first pktAck produces a one-cycle fifoAdvance in the next cycle, with advanceLen equal to that packet's length. A pktAck with no unacknowledged packet produces nothing.
- R8: A crcCmd pulse arms CRC corruption only while debugEn is 1. The next DATA reply carries replyBadCrc=1 and disarms it. NAK replies neither carry the mark nor consume it. A crcCmd pulse while debugEn is 0 has no effect.
- R9: inLvlSel selects the low-water mark as an occupancy of at most DEPTH*(3-inLvlSel)/4 bytes (00 = 75% full, 01 = half, 10 = 25% full, 11 = empty). lvlIrq is set one cycle after occupancy first enters that region, then stays set until a lvlIrqClr pulse. A new entry in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inToken | input | 1 | One-cycle strobe for an IN token addressed to this endpoint |
| fifoCount | input | CNT_W | Bytes currently held in the transmit FIFO |
| maxPkt | input | CNT_W | Configured maximum packet size (at least 1) |
| swDoneWr | input | 1 | Software write strobe for the done flag |
| swDoneVal | input | 1 | Value written to the done flag |
| debugEn | input | 1 | Debug enable that gates CRC corruption |
| crcCmd | input | 1 | One-shot write strobe requesting CRC corruption |
| inLvlSel | input | 2 | Low-water threshold select |
| lvlIrqClr | input | 1 | Write-one-to-clear strobe for lvlIrq |
| pktAck | input | 1 | Host acknowledged the last data packet |
| replyValid | output | 1 | Decision valid pulse |
| replyIsData | output | 1 | 1 = DATA, 0 = NAK |
| replyLen | output | CNT_W | Data packet length in bytes |
| replyBadCrc | output | 1 | Corrupt the CRC of this data packet |
| doneFlag | output | 1 | Transfer-done flag |
| fifoAdvance | output | 1 | Release advanceLen bytes from the FIFO |
| advanceLen | output | CNT_W | Number of bytes to release |
| lvlIrq | output | 1 | Sticky low-water interrupt |

## Verification
The embedded properties watch every cycle for the following. A NAK is only ever issued while the flag is set. A reply in full-packet mode always has the maximum length. A short packet always leaves the flag raised. The FIFO only moves after an acknowledgement. The flag rises only for an end of transfer or a write. A corruption mark disarms itself. The interrupt rises only from a low FIFO. The directed scenarios are needed to show complete transfer sequences: draining a multi-packet transfer down to its final short or zero-length packet, write/end-of-transfer collisions, the one-shot behaviour across NAKs and a disabled debug mode, and each threshold setting of the interrupt.

// File: rtl/inEpPkg.sv
`timescale 1ns/1ps
package inEpPkg;

  // Strobes from the control to the datapath for the current token.
  typedef struct packed {
    logic issueData;
    logic issueNak;
    logic corruptCrc;
  } ctlStrobes_t;

  // Condition flags from the datapath to the control.
  typedef struct packed {
    logic hasFull;
  } dpStatus_t;

endpackage

// File: rtl/inEpCtl.sv
`timescale 1ns/1ps
module inEpCtl
  import inEpPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inToken,
  input  logic        swDoneWr,
  input  logic        swDoneVal,
  input  logic        debugEn,
  input  logic        crcCmd,
  input  dpStatus_t   status,
  output ctlStrobes_t strobes,
  output logic        doneFlag
);

  logic crcArmed;
  logic eotEvent;

  // Token decision: full-only while done, drain anything otherwise.
  always_comb begin
    strobes = '0;
    if (inToken) begin
      if (!doneFlag || status.hasFull) strobes.issueData = 1'b1;
      else                             strobes.issueNak  = 1'b1;
    end
    strobes.corruptCrc = strobes.issueData && crcArmed && debugEn;
  end

  // A data packet that is not full ends the transfer.
  assign eotEvent = strobes.issueData && !status.hasFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneFlag <= 1'b1;
    end else if (eotEvent) begin
      doneFlag <= 1'b1;
    end else if (swDoneWr) begin
      doneFlag <= swDoneVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcArmed <= 1'b0;
    end else if (crcCmd && debugEn) begin
      crcArmed <= 1'b1;
    end else if (strobes.issueData) begin
      crcArmed <= 1'b0;
    end
  end

  AST_DONE_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> ($past(eotEvent) || ($past(swDoneWr) && $past(swDoneVal)))); // R4

  AST_CRC_ONESHOT: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.corruptCrc && !(crcCmd && debugEn)) |=> !crcArmed); // R8

endmodule

// File: rtl/inEpDatapath.sv
`timescale 1ns/1ps
module inEpDatapath
  import inEpPkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [CNT_W-1:0] maxPkt,
  input  logic [1:0]       inLvlSel,
  input  logic             lvlIrqClr,
  input  logic             pktAck,
  input  ctlStrobes_t      strobes,
  output dpStatus_t        status,
  output logic             replyValid,
  output logic             replyIsData,
  output logic [CNT_W-1:0] replyLen,
  output logic             replyBadCrc,
  output logic             fifoAdvance,
  output logic [CNT_W-1:0] advanceLen,
  output logic             lvlIrq
);

  localparam int LVL_N = 4;

  logic [CNT_W-1:0] pktLen;
  logic [CNT_W-1:0] pendLen;
  logic             pendValid;
  logic [CNT_W-1:0] thrTab [LVL_N];
  logic             lowNow;
  logic             lowPrev;

  // Low-water marks: occupancy at most DEPTH*(3-i)/4.
  generate
    for (genvar g = 0; g < LVL_N; g++) begin : gThr
      assign thrTab[g] = CNT_W'((DEPTH * (LVL_N - 1 - g)) / LVL_N);
    end
  endgenerate

  assign status.hasFull = (fifoCount >= maxPkt);
  assign pktLen         = status.hasFull ? maxPkt : fifoCount;
  assign lowNow         = (fifoCount <= thrTab[inLvlSel]);

  // Registered decision.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      replyValid  <= 1'b0;
      replyIsData <= 1'b0;
      replyLen    <= '0;
      replyBadCrc <= 1'b0;
    end else begin
      replyValid  <= strobes.issueData || strobes.issueNak;
      replyIsData <= strobes.issueData;
      replyLen    <= strobes.issueData ? pktLen : '0;
      replyBadCrc <= strobes.corruptCrc;
    end
  end

  // Outstanding packet, released to the FIFO on acknowledge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid   <= 1'b0;
      pendLen     <= '0;
      fifoAdvance <= 1'b0;
      advanceLen  <= '0;
    end else begin
      fifoAdvance <= pktAck && pendValid;
      advanceLen  <= pendLen;
      if (strobes.issueData) begin
        pendValid <= 1'b1;
        pendLen   <= pktLen;
      end else if (pktAck) begin
        pendValid <= 1'b0;
      end
    end
  end

  // Sticky low-water interrupt; a fresh crossing beats the clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowPrev <= 1'b1;
      lvlIrq  <= 1'b0;
    end else begin
      lowPrev <= lowNow;
      if (lowNow && !lowPrev) lvlIrq <= 1'b1;
      else if (lvlIrqClr)     lvlIrq <= 1'b0;
    end
  end

  AST_ADVANCE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    fifoAdvance |-> $past(pktAck)); // R7

  AST_LEN_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    (replyValid && replyIsData) |-> (replyLen <= $past(maxPkt))); // R3

  AST_IRQ_FROM_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lvlIrq) |-> $past(lowNow)); // R9

endmodule

// File: rtl/inEpTransferCtl.sv
`timescale 1ns/1ps
module inEpTransferCtl
  import inEpPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inToken,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [CNT_W-1:0] maxPkt,
  input  logic             swDoneWr,
  input  logic             swDoneVal,
  input  logic             debugEn,
  input  logic             crcCmd,
  input  logic [1:0]       inLvlSel,
  input  logic             lvlIrqClr,
  input  logic             pktAck,
  output logic             replyValid,
  output logic             replyIsData,
  output logic [CNT_W-1:0] replyLen,
  output logic             replyBadCrc,
  output logic             doneFlag,
  output logic             fifoAdvance,
  output logic [CNT_W-1:0] advanceLen,
  output logic             lvlIrq
);

  ctlStrobes_t strobes;
  dpStatus_t   status;

  inEpCtl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .inToken   (inToken),
    .swDoneWr  (swDoneWr),
    .swDoneVal (swDoneVal),
    .debugEn   (debugEn),
    .crcCmd    (crcCmd),
    .status    (status),
    .strobes   (strobes),
    .doneFlag  (doneFlag)
  );

  inEpDatapath #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .fifoCount   (fifoCount),
    .maxPkt      (maxPkt),
    .inLvlSel    (inLvlSel),
    .lvlIrqClr   (lvlIrqClr),
    .pktAck      (pktAck),
    .strobes     (strobes),
    .status      (status),
    .replyValid  (replyValid),
    .replyIsData (replyIsData),
    .replyLen    (replyLen),
    .replyBadCrc (replyBadCrc),
    .fifoAdvance (fifoAdvance),
    .advanceLen  (advanceLen),
    .lvlIrq      (lvlIrq)
  );

  AST_NAK_ONLY_WHEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (replyValid && !replyIsData) |-> $past(doneFlag)); // R2

  AST_DONE_MODE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (replyValid && replyIsData && $past(doneFlag)) |-> (replyLen == $past(maxPkt))); // R2

  AST_SHORT_ENDS_XFER: assert property (@(posedge clk) disable iff (!rstN)
    (replyValid && replyIsData && (replyLen < $past(maxPkt))) |-> doneFlag); // R5

  AST_BADCRC_ON_DATA: assert property (@(posedge clk) disable iff (!rstN)
    replyBadCrc |-> (replyValid && replyIsData && $past(debugEn))); // R8

endmodule

// File: tb/inEpTransferCtl_test.sv
`timescale 1ns/1ps
module inEpTransferCtl_test;

  localparam int DEPTH = 64;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inToken = 1'b0;
  logic [CNT_W-1:0] fifoCount = '0;
  logic [CNT_W-1:0] maxPkt = CNT_W'(16);
  logic             swDoneWr = 1'b0;
  logic             swDoneVal = 1'b0;
  logic             debugEn = 1'b0;
  logic             crcCmd = 1'b0;
  logic [1:0]       inLvlSel = 2'b00;
  logic             lvlIrqClr = 1'b0;
  logic             pktAck = 1'b0;
  logic             replyValid, replyIsData, replyBadCrc, doneFlag, fifoAdvance, lvlIrq;
  logic [CNT_W-1:0] replyLen, advanceLen;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  inEpTransferCtl #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .inToken(inToken), .fifoCount(fifoCount), .maxPkt(maxPkt),
    .swDoneWr(swDoneWr), .swDoneVal(swDoneVal), .debugEn(debugEn), .crcCmd(crcCmd),
    .inLvlSel(inLvlSel), .lvlIrqClr(lvlIrqClr), .pktAck(pktAck),
    .replyValid(replyValid), .replyIsData(replyIsData), .replyLen(replyLen),
    .replyBadCrc(replyBadCrc), .doneFlag(doneFlag), .fifoAdvance(fifoAdvance),
    .advanceLen(advanceLen), .lvlIrq(lvlIrq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Token, then sample the registered reply.
  task automatic token(input string tag, input int expData, input int expLen,
                       input int expBad, input int expDone);
    @(negedge clk) inToken = 1'b1;
    @(negedge clk) inToken = 1'b0;
    chk({tag, " valid"}, int'(replyValid), 1);
    chk({tag, " isData"}, int'(replyIsData), expData);
    chk({tag, " len"}, int'(replyLen), expLen);
    chk({tag, " badCrc"}, int'(replyBadCrc), expBad);
    chk({tag, " done"}, int'(doneFlag), expDone);
  endtask

  task automatic ack(input string tag, input int expAdv, input int expLen);
    @(negedge clk) pktAck = 1'b1;
    @(negedge clk) pktAck = 1'b0;
    chk({tag, " advance"}, int'(fifoAdvance), expAdv);
    if (expAdv != 0) chk({tag, " advanceLen"}, int'(advanceLen), expLen);
  endtask

  task automatic swWrite(input logic v);
    @(negedge clk) begin swDoneWr = 1'b1; swDoneVal = v; end
    @(negedge clk) swDoneWr = 1'b0;
    chk("R4 software write", int'(doneFlag), int'(v));
  endtask

  task automatic irqClear();
    @(negedge clk) lvlIrqClr = 1'b1;
    @(negedge clk) lvlIrqClr = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 done after reset", int'(doneFlag), 1);
    chk("R1 no reply", int'(replyValid), 0);
    chk("R1 no advance", int'(fifoAdvance), 0);
    chk("R1 no irq", int'(lvlIrq), 0);
  endtask

  task automatic testFullOnly();
    fifoCount = CNT_W'(10);
    token("R2 nak below max", 0, 0, 0, 1);
    step();
    chk("R7 nak no advance", int'(fifoAdvance), 0);
    ack("R7 ack with nothing pending", 0, 0);
    fifoCount = CNT_W'(20);
    token("R2 full packet", 1, 16, 0, 1);
    ack("R7 ack after full", 1, 16);
    step();
    chk("R7 advance single pulse", int'(fifoAdvance), 0);
  endtask

  task automatic testDrain();
    swWrite(1'b0);
    fifoCount = CNT_W'(40);
    token("R6 full keeps done low", 1, 16, 0, 0);
    ack("R3 ack 1", 1, 16);
    fifoCount = CNT_W'(24);
    token("R3 second full", 1, 16, 0, 0);
    ack("R3 ack 2", 1, 16);
    fifoCount = CNT_W'(8);
    token("R5 short ends transfer", 1, 8, 0, 1);
    ack("R3 ack short", 1, 8);
    swWrite(1'b0);
    fifoCount = CNT_W'(16);
    token("R6 exact max", 1, 16, 0, 0);
    ack("R6 ack exact", 1, 16);
    fifoCount = '0;
    token("R6 zero length ends transfer", 1, 0, 0, 1);
    ack("R7 ack zero length", 1, 0);
  endtask

  task automatic testCollision();
    swWrite(1'b0);
    fifoCount = CNT_W'(3);
    @(negedge clk) begin inToken = 1'b1; swDoneWr = 1'b1; swDoneVal = 1'b0; end
    @(negedge clk) begin inToken = 1'b0; swDoneWr = 1'b0; end
    chk("R4 end of transfer beats write", int'(doneFlag), 1);
    chk("R3 collision len", int'(replyLen), 3);
    ack("R7 collision ack", 1, 3);
    swWrite(1'b0);
    swWrite(1'b1);
  endtask

  task automatic testCrc();
    debugEn = 1'b0;
    @(negedge clk) crcCmd = 1'b1;
    @(negedge clk) crcCmd = 1'b0;
    fifoCount = CNT_W'(20);
    token("R8 no arm without debug", 1, 16, 0, 1);
    ack("R8 ack", 1, 16);
    debugEn = 1'b1;
    @(negedge clk) crcCmd = 1'b1;
    @(negedge clk) crcCmd = 1'b0;
    fifoCount = CNT_W'(5);
    token("R8 nak not marked", 0, 0, 0, 1);
    fifoCount = CNT_W'(20);
    token("R8 next data corrupted", 1, 16, 1, 1);
    ack("R8 ack corrupted", 1, 16);
    token("R8 one shot only", 1, 16, 0, 1);
    ack("R8 ack clean", 1, 16);
    debugEn = 1'b0;
  endtask

  task automatic testLevel();
    inLvlSel = 2'b01;
    fifoCount = CNT_W'(40);
    step();
    irqClear();
    chk("R9 cleared", int'(lvlIrq), 0);
    fifoCount = CNT_W'(32);
    step();
    chk("R9 half threshold set", int'(lvlIrq), 1);
    fifoCount = CNT_W'(20);
    irqClear();
    chk("R9 w1c clears", int'(lvlIrq), 0);
    step();
    chk("R9 no re-fire while low", int'(lvlIrq), 0);
    fifoCount = CNT_W'(40);
    step();
    fifoCount = CNT_W'(30);
    step();
    chk("R9 fires on new crossing", int'(lvlIrq), 1);
    fifoCount = CNT_W'(40);
    irqClear();
    @(negedge clk) begin fifoCount = CNT_W'(10); lvlIrqClr = 1'b1; end
    @(negedge clk) lvlIrqClr = 1'b0;
    chk("R9 set beats clear", int'(lvlIrq), 1);
    inLvlSel = 2'b11;
    fifoCount = CNT_W'(1);
    irqClear();
    step();
    chk("R9 empty mode not yet", int'(lvlIrq), 0);
    fifoCount = '0;
    step();
    chk("R9 empty mode fires", int'(lvlIrq), 1);
    inLvlSel = 2'b00;
    fifoCount = CNT_W'(50);
    irqClear();
    step();
    chk("R9 75pct mode quiet", int'(lvlIrq), 0);
    fifoCount = CNT_W'(48);
    step();
    chk("R9 75pct mode fires", int'(lvlIrq), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    testReset();
    testFullOnly();
    testDrain();
    testCollision();
    testCrc();
    testLevel();
    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule